// File: doc/BRIEF.md
# External Bus Arbiter with DMA Priority

This block decides which requester owns a shared external bus in each cycle. There are four kinds of contender. A memory refresh requester and an external bus-release requester are system-level claimants. A parameterised set of internal masters, such as the CPU and other transfer engines, share one class. The external DMA engine sits in a class of its own. The DMA engine reports the phase of its transfer cycles to the arbiter: a read has finished, or the paired write has finished. It also reports its transfer mode, the end of a burst, the end of a block, a pending switch to another channel, and a give-up control bit. From these the arbiter works out where the bus may legally change hands.

The bus never leaves the DMA engine between a read and the write paired with it. At the boundary after a write, refresh or external release may slip in. Internal masters must wait for a true release point, which depends on the mode, on a channel switch and on the give-up bit. When the DMA engine is displaced at a boundary that is not a release point, it keeps a claim on the bus. It takes the bus back ahead of the internal masters once the inserted cycle completes. All grants are one-hot and registered.

Top module: `ebus_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, every grant is low and the arbiter is idle.
- R2: At most one grant output is high in any cycle.
- R3: When the bus is free, the grant goes to the winning requester at the next clock edge. The ranking is refresh, then external release, then internal masters, then DMA. With no request pending, no grant is given.
- R4: Among internal masters, the lowest-indexed requesting master wins.
- R5: A refresh, external-release or internal-master holder keeps its grant for as long as its request stays high. The bus becomes free in the cycle in which that request is low.
- R6: After a read-done pulse, the DMA engine keeps the bus until its write-done pulse, even if its request drops in between.
- R7: With mode 2'b00 (cycle steal), or with the reserved mode 2'b11, every write-done is a release point.
- R8: In mode 2'b01 (burst), write-done is a release point only when the end-of-burst flag is high.
- R9: In mode 2'b10 (block), write-done is a release point only when the end-of-block flag is high.
- R10: A write-done with the channel-switch flag high is a release point in any mode.
- R11: With the give-up bit high, every write-done in burst or block mode is a release point.
- R12: At a write-done that is not a release point, a pending refresh or external-release request takes the bus, and a pending internal master does not.
- R13: After such an insertion, the DMA engine ranks above the internal masters when the bus next becomes free, provided its request is still high. If its request is low, the internal masters compete normally.
- R14: A DMA holder whose request is low outside a read/write pair gives up the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_req | input | 1 | Refresh requester |
| ext_req | input | 1 | External bus-release requester |
| int_req | input | NUM_INT | Internal master requests, bit 0 highest rank |
| dma_req | input | 1 | DMA engine request |
| dma_rd_done | input | 1 | DMA read cycle finished, paired write pending |
| dma_wr_done | input | 1 | DMA write cycle finished, transfer complete |
| dma_mode | input | 2 | 00 cycle steal, 01 burst, 10 block, 11 treated as cycle steal |
| dma_last | input | 1 | End of burst, qualified by write-done |
| dma_blk_end | input | 1 | End of block, qualified by write-done |
| dma_chan_sw | input | 1 | Next transfer is on another channel |
| dma_give_up | input | 1 | Release the bus between transfers in burst and block modes |
| gnt_ref | output | 1 | Grant to refresh |
| gnt_ext | output | 1 | Grant to external release |
| gnt_int | output | NUM_INT | One-hot grant to internal masters |
| gnt_dma | output | 1 | Grant to the DMA engine |

## Verification
The bench builds the arbiter with NUM_INT set to 3. This keeps every vector in the table readable, and it still lets a single step present several internal masters at once, so the lowest-index ranking and the ranking of internal masters against DMA are both observed. The table leads the DMA engine through read/write pairs in every mode code, including the reserved one. It also covers a channel switch and the give-up bit, and it drops the DMA request mid-pair. Refresh and external release are inserted at non-release boundaries, so the reclaim rule is exercised both with the DMA request still high and with it already dropped.

// File: rtl/ebus_arb_pkg.sv
package ebus_arb_pkg;

  typedef enum logic [1:0] {
    XM_STEAL = 2'b00,
    XM_BURST = 2'b01,
    XM_BLOCK = 2'b10,
    XM_RSVD  = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    OWN_IDLE = 3'd0,
    OWN_REF  = 3'd1,
    OWN_EXT  = 3'd2,
    OWN_INT  = 3'd3,
    OWN_DMA  = 3'd4
  } owner_e;

endpackage

// File: rtl/ebus_dma_tracker.sv
module ebus_dma_tracker
  import ebus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dma_owns,
  input  logic       dma_req,
  input  logic       rd_done,
  input  logic       wr_done,
  input  logic [1:0] mode,
  input  logic       last,
  input  logic       blk_end,
  input  logic       chan_sw,
  input  logic       give_up,
  output logic       pair_open,
  output logic       locked,
  output logic       boundary,
  output logic       release_pt
);

  xfer_mode_e mode_e;
  logic       mode_rel;

  assign mode_e = xfer_mode_e'(mode);

  // Which pair boundaries count as release points for the current mode
  always_comb begin
    case (mode_e)
      XM_BURST: mode_rel = last | give_up;
      XM_BLOCK: mode_rel = blk_end | give_up;
      default:  mode_rel = 1'b1;
    endcase
  end

  // A read has completed and its write has not
  always_ff @(posedge clk) begin
    if (rst)                      pair_open <= 1'b0;
    else if (dma_owns && wr_done) pair_open <= 1'b0;
    else if (dma_owns && rd_done) pair_open <= 1'b1;
  end

  assign boundary   = dma_owns & wr_done;
  assign locked     = dma_owns & ((pair_open & ~wr_done) | (rd_done & ~wr_done));
  assign release_pt = dma_owns & ((boundary & (mode_rel | chan_sw)) | (~dma_req & ~locked));

  // R6: a write-done always closes the pair
  p_pair_close_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_owns && wr_done) |=> !pair_open);

  // R6: a read-done opens a pair unless the write also completes
  p_pair_open_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_owns && rd_done && !wr_done) |=> pair_open);

endmodule

// File: rtl/ebus_int_pick.sv
module ebus_int_pick #(
  parameter int NUM_INT = 4
) (
  input  logic [NUM_INT-1:0] req,
  output logic [NUM_INT-1:0] pick,
  output logic               any
);

  logic [NUM_INT:0] seen;

  assign seen[0] = 1'b0;

  // Fixed ranking: a bit wins only if no lower-indexed bit is requesting
  for (genvar i = 0; i < NUM_INT; i++) begin : g_rank
    assign pick[i]   = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[NUM_INT];

  // R4: the pick is a single master, and present whenever any request is
  always_comb begin
    p_pick_onehot_r4: assert ($onehot0(pick));
    p_pick_any_r4: assert ((|pick) == any);
  end

endmodule

// File: rtl/ebus_grant_ctrl.sv
module ebus_grant_ctrl
  import ebus_arb_pkg::*;
#(
  parameter int NUM_INT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_req,
  input  logic               ext_req,
  input  logic [NUM_INT-1:0] int_req,
  input  logic               dma_req,
  input  logic [NUM_INT-1:0] int_pick,
  input  logic               int_any,
  input  logic               boundary,
  input  logic               release_pt,
  input  logic               locked,
  output logic               gnt_ref,
  output logic               gnt_ext,
  output logic [NUM_INT-1:0] gnt_int,
  output logic               gnt_dma
);

  owner_e             own_q, own_d;
  logic [NUM_INT-1:0] isel_q, isel_d;
  logic               hold_q, hold_d;
  logic               free, insert, int_keep;

  assign int_keep = |(int_req & isel_q);

  // The bus is free once the current holder reaches its hand-over point
  always_comb begin
    case (own_q)
      OWN_IDLE: free = 1'b1;
      OWN_REF:  free = ~ref_req;
      OWN_EXT:  free = ~ext_req;
      OWN_INT:  free = ~int_keep;
      OWN_DMA:  free = release_pt;
      default:  free = 1'b1;
    endcase
  end

  assign insert = (own_q == OWN_DMA) & boundary & ~release_pt & (ref_req | ext_req);

  always_comb begin
    own_d  = own_q;
    isel_d = isel_q;
    hold_d = hold_q;
    if (free) begin
      isel_d = '0;
      if (ref_req)               own_d = OWN_REF;
      else if (ext_req)          own_d = OWN_EXT;
      else if (hold_q && dma_req) own_d = OWN_DMA;
      else if (int_any) begin
        own_d  = OWN_INT;
        isel_d = int_pick;
      end
      else if (dma_req)          own_d = OWN_DMA;
      else                       own_d = OWN_IDLE;
    end else if (insert) begin
      own_d  = ref_req ? OWN_REF : OWN_EXT;
      hold_d = 1'b1;
    end
    if (own_d == OWN_DMA || !dma_req) hold_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q   <= OWN_IDLE;
      isel_q  <= '0;
      hold_q  <= 1'b0;
      gnt_ref <= 1'b0;
      gnt_ext <= 1'b0;
      gnt_int <= '0;
      gnt_dma <= 1'b0;
    end else begin
      own_q   <= own_d;
      isel_q  <= isel_d;
      hold_q  <= hold_d;
      gnt_ref <= (own_d == OWN_REF);
      gnt_ext <= (own_d == OWN_EXT);
      gnt_int <= (own_d == OWN_INT) ? isel_d : '0;
      gnt_dma <= (own_d == OWN_DMA);
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!gnt_ref && !gnt_ext && gnt_int == '0 && !gnt_dma));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_ref, gnt_ext, gnt_int, gnt_dma}));

  p_ref_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt_ref && ref_req) |=> gnt_ref);

  p_ext_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt_ext && ext_req) |=> gnt_ext);

  p_midpair_r6: assert property (@(posedge clk) disable iff (rst)
    (gnt_dma && locked) |=> gnt_dma);

  p_int_waits_r12: assert property (@(posedge clk) disable iff (rst)
    (gnt_dma && !release_pt) |=> (gnt_int == '0));

  p_reclaim_r13: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (gnt_int == '0));

endmodule

// File: rtl/ebus_arbiter.sv
module ebus_arbiter #(
  parameter int NUM_INT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_req,
  input  logic               ext_req,
  input  logic [NUM_INT-1:0] int_req,
  input  logic               dma_req,
  input  logic               dma_rd_done,
  input  logic               dma_wr_done,
  input  logic [1:0]         dma_mode,
  input  logic               dma_last,
  input  logic               dma_blk_end,
  input  logic               dma_chan_sw,
  input  logic               dma_give_up,
  output logic               gnt_ref,
  output logic               gnt_ext,
  output logic [NUM_INT-1:0] gnt_int,
  output logic               gnt_dma
);

  logic               pair_open, locked, boundary, release_pt;
  logic [NUM_INT-1:0] int_pick;
  logic               int_any;

  ebus_dma_tracker u_trk (
    .clk        (clk),
    .rst        (rst),
    .dma_owns   (gnt_dma),
    .dma_req    (dma_req),
    .rd_done    (dma_rd_done),
    .wr_done    (dma_wr_done),
    .mode       (dma_mode),
    .last       (dma_last),
    .blk_end    (dma_blk_end),
    .chan_sw    (dma_chan_sw),
    .give_up    (dma_give_up),
    .pair_open  (pair_open),
    .locked     (locked),
    .boundary   (boundary),
    .release_pt (release_pt)
  );

  ebus_int_pick #(.NUM_INT(NUM_INT)) u_pick (
    .req  (int_req),
    .pick (int_pick),
    .any  (int_any)
  );

  ebus_grant_ctrl #(.NUM_INT(NUM_INT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ref_req    (ref_req),
    .ext_req    (ext_req),
    .int_req    (int_req),
    .dma_req    (dma_req),
    .int_pick   (int_pick),
    .int_any    (int_any),
    .boundary   (boundary),
    .release_pt (release_pt),
    .locked     (locked),
    .gnt_ref    (gnt_ref),
    .gnt_ext    (gnt_ext),
    .gnt_int    (gnt_int),
    .gnt_dma    (gnt_dma)
  );

  // R6: an open pair means the DMA engine must be the holder
  p_pair_owner_r6: assert property (@(posedge clk) disable iff (rst)
    pair_open |-> gnt_dma);

endmodule

// File: tb/ebus_arbiter_test.sv
`timescale 1ns/1ps
module ebus_arbiter_test;

  localparam int NI = 3;
  localparam int NV = 41;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_req = 1'b0, ext_req = 1'b0, dma_req = 1'b0;
  logic [NI-1:0] int_req = '0;
  logic          rd = 1'b0, wr = 1'b0, last = 1'b0, blk = 1'b0, sw = 1'b0, gu = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          gnt_ref, gnt_ext, gnt_dma;
  logic [NI-1:0] gnt_int;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ebus_arbiter #(.NUM_INT(NI)) uut (
    .clk(clk), .rst(rst), .ref_req(ref_req), .ext_req(ext_req), .int_req(int_req),
    .dma_req(dma_req), .dma_rd_done(rd), .dma_wr_done(wr), .dma_mode(mode),
    .dma_last(last), .dma_blk_end(blk), .dma_chan_sw(sw), .dma_give_up(gu),
    .gnt_ref(gnt_ref), .gnt_ext(gnt_ext), .gnt_int(gnt_int), .gnt_dma(gnt_dma)
  );

  // Fields: tag(4) ref ext int(3) dreq rd wr mode(2) last blk sw gu | expected {ref,ext,i2,i1,i0,dma}
  localparam logic [23:0] VEC [NV] = '{
    24'b0001_0_0_000_0_0_0_00_0_0_0_0_000000, // R1 idle
    24'b0011_0_0_000_1_0_0_00_0_0_0_0_000001, // R3 dma alone
    24'b0110_0_0_001_1_1_0_01_0_0_0_0_000001, // R6 read opens pair
    24'b0110_1_0_001_0_0_0_01_0_0_0_0_000001, // R6 locked, req dropped
    24'b1100_1_0_001_1_0_1_01_0_0_0_0_100000, // R12 refresh inserted
    24'b0101_1_0_001_1_0_0_01_0_0_0_0_100000, // R5 refresh keeps
    24'b1101_0_0_001_1_0_0_01_0_0_0_0_000001, // R13 dma reclaims over int
    24'b0110_0_0_001_1_1_0_01_0_0_0_0_000001, // R6
    24'b1000_0_0_001_1_0_1_01_1_0_0_0_000010, // R8 end of burst
    24'b0101_0_0_011_1_0_0_01_0_0_0_0_000010, // R5 int0 keeps
    24'b0011_0_0_010_1_0_0_01_0_0_0_0_000100, // R3 int over dma
    24'b0011_0_1_000_1_0_0_01_0_0_0_0_010000, // R3 ext over dma
    24'b0101_0_0_000_1_0_0_01_0_0_0_0_000001, // R5 ext done
    24'b0110_0_0_100_1_1_0_10_0_0_0_0_000001, // R6 block
    24'b1001_0_0_100_1_0_1_10_0_0_0_0_000001, // R9 R12 mid block, int waits
    24'b0110_0_0_100_1_1_0_10_0_0_0_0_000001, // R6
    24'b1001_0_0_100_1_0_1_10_0_1_0_0_001000, // R9 end of block
    24'b0011_0_0_000_1_0_0_10_0_0_0_0_000001, // R3
    24'b0110_0_0_010_1_1_0_00_0_0_0_0_000001, // R6 steal
    24'b0111_0_0_010_1_0_1_00_0_0_0_0_000100, // R7 steal release
    24'b0011_0_0_000_1_0_0_00_0_0_0_0_000001, // R3
    24'b0110_0_0_001_1_1_0_01_0_0_0_0_000001, // R6
    24'b1011_0_0_001_1_0_1_01_0_0_0_1_000010, // R11 give-up
    24'b0011_0_0_000_1_0_0_01_0_0_0_0_000001, // R3
    24'b0110_0_0_100_1_1_0_01_0_0_0_0_000001, // R6
    24'b1010_0_0_100_1_0_1_01_0_0_1_0_001000, // R10 channel switch
    24'b0011_0_0_000_1_0_0_01_0_0_0_0_000001, // R3
    24'b0110_0_0_001_1_1_0_11_0_0_0_0_000001, // R6 reserved mode
    24'b0111_0_0_001_1_0_1_11_0_0_0_0_000010, // R7 reserved acts as steal
    24'b0101_0_0_000_0_0_0_00_0_0_0_0_000000, // R5 int done, idle
    24'b0011_0_0_000_1_0_0_00_0_0_0_0_000001, // R3
    24'b1110_0_0_000_0_0_0_00_0_0_0_0_000000, // R14 dma drops outside pair
    24'b0011_1_1_111_1_0_0_00_0_0_0_0_100000, // R3 all pending
    24'b0101_0_1_111_1_0_0_00_0_0_0_0_010000, // R5
    24'b0100_0_0_110_1_0_0_00_0_0_0_0_000100, // R4 lowest index
    24'b0101_0_0_000_0_0_0_00_0_0_0_0_000000, // R5
    24'b0011_0_0_000_1_0_0_00_0_0_0_0_000001, // R3
    24'b0110_0_0_001_1_1_0_01_0_0_0_0_000001, // R6
    24'b1100_0_1_001_1_0_1_01_0_0_0_0_010000, // R12 ext inserted
    24'b1101_0_0_001_0_0_0_01_0_0_0_0_000010, // R13 dma gone, int wins
    24'b0101_0_0_000_0_0_0_00_0_0_0_0_000000  // R5
  };

  function automatic logic [5:0] gvec();
    return {gnt_ref, gnt_ext, gnt_int, gnt_dma};
  endfunction

  task automatic check(input int tag, input logic [5:0] exp);
    checks++;
    if (gvec() !== exp) begin
      fails++;
      $display("FAIL R%0d: grants %b expected %b", tag, gvec(), exp);
    end
    checks++;
    if ($countones(gvec()) > 1) begin // R2 at most one grant
      fails++;
      $display("FAIL R2: grants %b expected at most one set", gvec());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #50000;
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 6'b000000); // R1 held in reset
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {ref_req, ext_req, int_req, dma_req, rd, wr, mode, last, blk, sw, gu} = VEC[i][19:6];
      @(negedge clk);
      check(int'(VEC[i][23:20]), VEC[i][5:0]);
    end
    // Directed: reset while a grant is held (R1), then regrant (R3)
    {ref_req, ext_req, dma_req, rd, wr, mode, last, blk, sw, gu} = '0;
    int_req = 3'b001;
    @(negedge clk);
    check(3, 6'b000010);
    rst = 1'b1;
    @(negedge clk);
    check(1, 6'b000000);
    ref_req = 1'b1;
    @(negedge clk);
    check(1, 6'b000000); // R1 requests ignored in reset
    rst = 1'b0;
    @(negedge clk);
    check(3, 6'b100000);
    finish_run();
  end

endmodule